// File: doc/BRIEF.md
# Embedded Controller Register Access Sequencer

This block lets host-side logic read or write one byte inside an embedded controller's private register space. The controller is reached through two byte-wide ports: a data port at offset 0, and a port at offset 4 that returns status when read and takes commands when written. A caller presents one request: a direction, an 8-bit internal address and, for writes, an 8-bit value. The sequencer then walks the handshake. Before it moves each byte it polls the status byte until the controller is ready for it. When the operation ends it pulses a done strobe, together with a timeout flag and, after a read, the byte it fetched.

Every wait is bounded. The status byte is read at most `MAX_POLLS` times per wait, and successive polls are spaced by a pause of `TICK_CYCLES` clocks (one microsecond at the default clock). If a wait uses up its budget, the operation ends at once with the timeout flag set and issues no further port access. Status bit 1 set means the controller has not yet consumed the last byte written (input busy). Status bit 0 set means a byte is waiting for the host (output ready).

The state machine has these states: IDLE, POLL (status read strobe), SAMPLE (judge the returned status), GAP (pause between polls), SEND_CMD, SEND_ADDR, SEND_DATA, FETCH (data port read strobe), CAPTURE and FINISH. Its transitions are:
- accept: IDLE to POLL on a request.
- sample: POLL to SAMPLE.
- retry: SAMPLE to GAP when the condition fails and budget remains.
- repoll: GAP to POLL after `TICK_CYCLES` clocks.
- proceed: SAMPLE to SEND_CMD, SEND_ADDR, SEND_DATA or FETCH, depending on the current step, when the condition holds.
- give-up: SAMPLE to FINISH when the last allowed poll fails.
- advance: SEND_CMD or SEND_ADDR back to POLL.
- fetch: FETCH to CAPTURE.
- complete: SEND_DATA or CAPTURE to FINISH.
- release: FINISH to IDLE.

Top module: `ec_access_seq`

## Requirements
- R1: After reset the block is in IDLE. `req_ready` is 1, `rsp_done` is 0, and neither `port_rd` nor `port_wr` is asserted. No port strobe is ever issued while `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle after `rsp_done`. `req_valid` and the request fields are ignored while busy, and the operation proceeds on the latched values.
- R3: A status poll is one cycle with `port_rd`=1 and `port_addr`=4. The status byte is taken from `port_rdata` in the following cycle. A port access only ever uses offset 0 or offset 4.
- R4: A read runs: wait for input-busy (bit 1) clear, write 0x80 to offset 4, wait for input-busy clear, write the address to offset 0, wait for output-ready (bit 0) set, read offset 0, capture the byte one cycle later.
- R5: A write runs: wait for input-busy clear, write 0x81 to offset 4, wait for input-busy clear, write the address to offset 0, wait for input-busy clear, write the data byte to offset 0.
- R6: After a failed poll, exactly `TICK_CYCLES` idle cycles pass before the next status read strobe.
- R7: Each wait allows up to `MAX_POLLS` status reads, and a condition met on the last allowed read lets the operation proceed. The budget restarts for every wait.
- R8: If `MAX_POLLS` reads of one wait all fail, the next cycle is FINISH with `rsp_done`=1 and `rsp_timeout`=1, and no later port access of that operation is issued. A write aborted this way leaves the controller's register unchanged.
- R9: `rsp_done` lasts one cycle. `rsp_timeout` is valid in that cycle and is 0 on success. After a successful read, `rsp_rdata` holds the byte captured from the data port.
- R10: The output-ready wait looks only at bit 0 and ignores input-busy. The input-busy waits look only at bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_is_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 8 | Controller-internal register address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_timeout | output | 1 | Operation aborted on a wait budget, valid with done |
| rsp_rdata | output | 8 | Byte returned by a read |
| port_addr | output | 3 | Port offset (0 data, 4 status/command) |
| port_rd | output | 1 | Port read strobe |
| port_wr | output | 1 | Port write strobe |
| port_wdata | output | 8 | Byte driven on a port write |
| port_rdata | input | 8 | Port read data, valid one cycle after `port_rd` |

## Verification
The bench builds the sequencer with `TICK_CYCLES`=3 and `MAX_POLLS`=5. The short pause makes the poll spacing visible in a few cycles. The small budget makes both edges of every wait reachable: success on the fifth and last allowed poll, and a timeout at each of the three wait positions. It also covers a read wait that must ignore a set busy bit, and a budget that restarts after several failed polls in an earlier wait.

// File: rtl/ec_seq_pkg.sv
package ec_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL,
        ST_SAMPLE,
        ST_GAP,
        ST_SEND_CMD,
        ST_SEND_ADDR,
        ST_SEND_DATA,
        ST_FETCH,
        ST_CAPTURE,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        STEP_CMD,
        STEP_ADDR,
        STEP_DATA
    } seq_step_t;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_CTRL = 3'd4;

    localparam logic [7:0] OPC_READ  = 8'h80;
    localparam logic [7:0] OPC_WRITE = 8'h81;

    localparam int BIT_IN_BUSY  = 1;
    localparam int BIT_OUT_RDY  = 0;

endpackage

// File: rtl/ec_gap_timer.sv
module ec_gap_timer #(
    parameter int TICK_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(TICK_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == CW'(TICK_CYCLES - 1));
endmodule

// File: rtl/ec_poll_budget.sv
module ec_poll_budget #(
    parameter int MAX_POLLS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic final_poll
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] used_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            used_q <= '0;
        end else if (bump) begin
            used_q <= used_q + 1'b1;
        end
    end

    assign final_poll = (used_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/ec_access_seq.sv
module ec_access_seq
    import ec_seq_pkg::*;
#(
    parameter int TICK_CYCLES = 125,
    parameter int MAX_POLLS   = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_is_read,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       rsp_done,
    output logic       rsp_timeout,
    output logic [7:0] rsp_rdata,
    output logic [2:0] port_addr,
    output logic       port_rd,
    output logic       port_wr,
    output logic [7:0] port_wdata,
    input  logic [7:0] port_rdata
);
    seq_state_t state_q, state_d;
    seq_step_t  step_q;
    logic       op_rd_q;
    logic [7:0] addr_q;
    logic [7:0] wdata_q;
    logic [7:0] rdata_q;
    logic       timeout_q;

    logic accept;
    logic want_out_rdy;
    logic poll_ok;
    logic gap_last;
    logic final_poll;
    logic budget_clear;
    logic budget_bump;

    assign accept       = (state_q == ST_IDLE) && req_valid;
    assign want_out_rdy = op_rd_q && (step_q == STEP_DATA);
    assign poll_ok      = want_out_rdy ? port_rdata[BIT_OUT_RDY]
                                       : !port_rdata[BIT_IN_BUSY];
    assign budget_clear = (state_q == ST_IDLE) || ((state_q == ST_SAMPLE) && poll_ok);
    assign budget_bump  = (state_q == ST_SAMPLE) && !poll_ok;

    ec_gap_timer #(.TICK_CYCLES(TICK_CYCLES)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_GAP),
        .last  (gap_last)
    );

    ec_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (budget_clear),
        .bump       (budget_bump),
        .final_poll (final_poll)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_POLL;
            ST_POLL:      state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                if (poll_ok) begin
                    unique case (step_q)
                        STEP_CMD:  state_d = ST_SEND_CMD;
                        STEP_ADDR: state_d = ST_SEND_ADDR;
                        default:   state_d = op_rd_q ? ST_FETCH : ST_SEND_DATA;
                    endcase
                end else if (final_poll) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP:       if (gap_last) state_d = ST_POLL;
            ST_SEND_CMD:  state_d = ST_POLL;
            ST_SEND_ADDR: state_d = ST_POLL;
            ST_SEND_DATA: state_d = ST_FINISH;
            ST_FETCH:     state_d = ST_CAPTURE;
            ST_CAPTURE:   state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // request latch, step tracking and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_rd_q   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            step_q    <= STEP_CMD;
            rdata_q   <= '0;
            timeout_q <= 1'b0;
        end else begin
            if (accept) begin
                op_rd_q   <= req_is_read;
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                step_q    <= STEP_CMD;
                timeout_q <= 1'b0;
            end
            if (state_q == ST_SEND_CMD)  step_q <= STEP_ADDR;
            if (state_q == ST_SEND_ADDR) step_q <= STEP_DATA;
            if (budget_bump && final_poll) timeout_q <= 1'b1;
            if (state_q == ST_CAPTURE) rdata_q <= port_rdata;
        end
    end

    // outputs
    always_comb begin
        port_rd     = 1'b0;
        port_wr     = 1'b0;
        port_addr   = OFS_DATA;
        port_wdata  = '0;
        rsp_done    = 1'b0;
        rsp_timeout = 1'b0;
        req_ready   = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_POLL: begin
                port_rd   = 1'b1;
                port_addr = OFS_CTRL;
            end
            ST_SEND_CMD: begin
                port_wr    = 1'b1;
                port_addr  = OFS_CTRL;
                port_wdata = op_rd_q ? OPC_READ : OPC_WRITE;
            end
            ST_SEND_ADDR: begin
                port_wr    = 1'b1;
                port_wdata = addr_q;
            end
            ST_SEND_DATA: begin
                port_wr    = 1'b1;
                port_wdata = wdata_q;
            end
            ST_FETCH:     port_rd = 1'b1;
            ST_FINISH: begin
                rsp_done    = 1'b1;
                rsp_timeout = timeout_q;
            end
            default: ;
        endcase
    end

    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/ec_access_seq_chk.sv
module ec_access_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_done,
    input logic       rsp_timeout,
    input logic [2:0] port_addr,
    input logic       port_rd,
    input logic       port_wr,
    input logic [7:0] port_wdata
);
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!port_rd && !port_wr)); // R1

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> req_ready); // R2

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_rd && port_wr)); // R3

    AST_PORT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd || port_wr) |-> (port_addr == 3'd0 || port_addr == 3'd4)); // R3

    AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_addr == 3'd4) |-> (port_wdata == 8'h80 || port_wdata == 8'h81)); // R4

    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_done); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9
endmodule

bind ec_access_seq ec_access_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rsp_timeout (rsp_timeout),
    .port_addr   (port_addr),
    .port_rd     (port_rd),
    .port_wr     (port_wr),
    .port_wdata  (port_wdata)
);

// File: tb/tb_ec_access_seq.sv
module tb_ec_access_seq;
    localparam int TICK = 3;
    localparam int MAXP = 5;
    localparam int NEVER = 99;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_is_read = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_done;
    logic       rsp_timeout;
    logic [7:0] rsp_rdata;
    logic [2:0] port_addr;
    logic       port_rd;
    logic       port_wr;
    logic [7:0] port_wdata;
    logic [7:0] port_rdata = '0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ec_access_seq #(.TICK_CYCLES(TICK), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_read(req_is_read),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
        .port_addr(port_addr), .port_rd(port_rd), .port_wr(port_wr),
        .port_wdata(port_wdata), .port_rdata(port_rdata)
    );

    // ---------------- behavioural controller on the two ports ----------------
    logic [7:0] ec_mem [256];
    int         fail_left [3];
    int         widx = 0;
    logic [7:0] r_cmd = '0;
    logic [7:0] r_addr = '0;
    int         r_phase = 0;

    always @(posedge clk) begin
        if (port_rd) begin
            if (port_addr == 3'd4) begin
                if (widx < 3 && fail_left[widx] == 0) begin
                    port_rdata <= (widx == 2 && r_cmd == 8'h80) ? 8'h03 : 8'hFD;
                    widx <= widx + 1;
                end else begin
                    port_rdata <= 8'hFE;
                    if (widx < 3) fail_left[widx] <= fail_left[widx] - 1;
                end
            end else begin
                port_rdata <= ec_mem[r_addr];
            end
        end
        if (port_wr) begin
            if (port_addr == 3'd4) begin
                r_cmd   <= port_wdata;
                r_phase <= 1;
            end else if (r_phase == 1) begin
                r_addr  <= port_wdata;
                r_phase <= 2;
            end else if (r_phase == 2) begin
                if (r_cmd == 8'h81) ec_mem[r_addr] <= port_wdata;
                r_phase <= 0;
            end
        end
    end

    // ---------------- expected per-cycle trace ----------------
    typedef struct {
        bit       rd;
        bit       wr;
        bit [2:0] a;
        bit [7:0] wd;
        bit       dn;
        bit       er;
        bit       ck;
        bit [7:0] rv;
        string    tag;
    } cyc_t;

    cyc_t exp_q[$];

    task automatic push_cyc(bit rd, bit wr, bit [2:0] a, bit [7:0] wd,
                            bit dn, bit er, bit ck, bit [7:0] rv, string tag);
        cyc_t c;
        c.rd = rd; c.wr = wr; c.a = a; c.wd = wd;
        c.dn = dn; c.er = er; c.ck = ck; c.rv = rv; c.tag = tag;
        exp_q.push_back(c);
    endtask

    task automatic build_trace(bit rd, bit [7:0] a, bit [7:0] d, int b0, int b1, int b2,
                               bit [7:0] rv);
        int  budgets [3];
        bit  abort = 1'b0;
        budgets[0] = b0; budgets[1] = b1; budgets[2] = b2;
        for (int w = 0; w < 3; w++) begin
            if (!abort) begin
                for (int p = 0; p < MAXP; p++) begin
                    push_cyc(1, 0, 3'd4, 8'h00, 0, 0, 0, 8'h00, "R3");
                    if (p < budgets[w]) begin
                        if (p == MAXP - 1) begin
                            push_cyc(0, 0, 3'd0, 8'h00, 0, 0, 0, 8'h00, "R7");
                            push_cyc(0, 0, 3'd0, 8'h00, 1, 1, 0, 8'h00, "R8");
                            abort = 1'b1;
                            break;
                        end
                        push_cyc(0, 0, 3'd0, 8'h00, 0, 0, 0, 8'h00, "R7");
                        for (int g = 0; g < TICK; g++)
                            push_cyc(0, 0, 3'd0, 8'h00, 0, 0, 0, 8'h00, "R6");
                    end else begin
                        push_cyc(0, 0, 3'd0, 8'h00, 0, 0, 0, 8'h00, "R10");
                        break;
                    end
                end
                if (!abort) begin
                    if (w == 0) begin
                        push_cyc(0, 1, 3'd4, rd ? 8'h80 : 8'h81, 0, 0, 0, 8'h00, rd ? "R4" : "R5");
                    end else if (w == 1) begin
                        push_cyc(0, 1, 3'd0, a, 0, 0, 0, 8'h00, rd ? "R4" : "R5");
                    end else if (rd) begin
                        push_cyc(1, 0, 3'd0, 8'h00, 0, 0, 0, 8'h00, "R4");
                        push_cyc(0, 0, 3'd0, 8'h00, 0, 0, 0, 8'h00, "R4");
                        push_cyc(0, 0, 3'd0, 8'h00, 1, 0, 1, rv, "R9");
                    end else begin
                        push_cyc(0, 1, 3'd0, d, 0, 0, 0, 8'h00, "R5");
                        push_cyc(0, 0, 3'd0, 8'h00, 1, 0, 0, 8'h00, "R9");
                    end
                end
            end
        end
    endtask

    task automatic run_op(bit rd, bit [7:0] a, bit [7:0] d,
                          int b0, int b1, int b2, bit hold);
        bit [7:0] rv;
        int       n = 0;
        rv = ec_mem[a];
        exp_q.delete();
        build_trace(rd, a, d, b0, b1, b2, rv);
        fail_left[0] = b0; fail_left[1] = b1; fail_left[2] = b2;
        widx = 0;
        @(negedge clk);
        req_valid   = 1'b1;
        req_is_read = rd;
        req_addr    = a;
        req_wdata   = d;
        while (exp_q.size() > 0) begin
            cyc_t e;
            bit   bad;
            @(negedge clk);
            if (n == 0) begin
                if (hold) begin
                    req_is_read = ~rd;
                    req_addr    = ~a;
                    req_wdata   = ~d;
                end else begin
                    req_valid = 1'b0;
                end
            end
            e = exp_q.pop_front();
            bad = (port_rd != e.rd) || (port_wr != e.wr) ||
                  ((e.rd || e.wr) && port_addr != e.a) ||
                  (e.wr && port_wdata != e.wd) ||
                  (rsp_done != e.dn) || (e.dn && rsp_timeout != e.er) ||
                  (e.ck && rsp_rdata != e.rv) || (req_ready != 1'b0);
            checks++;
            if (bad) begin
                failures++;
                $display("FAIL %s step %0d: got rd=%0b wr=%0b a=%0d wd=%02h dn=%0b to=%0b rdat=%02h rdy=%0b exp rd=%0b wr=%0b a=%0d wd=%02h dn=%0b to=%0b rdat=%02h rdy=0",
                         e.tag, n, port_rd, port_wr, port_addr, port_wdata, rsp_done,
                         rsp_timeout, rsp_rdata, req_ready,
                         e.rd, e.wr, e.a, e.wd, e.dn, e.er, e.rv);
            end
            if (e.dn) req_valid = 1'b0;
            n++;
        end
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1 || port_rd || port_wr || rsp_done) begin
            failures++;
            $display("FAIL R2 idle after done: got rdy=%0b rd=%0b wr=%0b dn=%0b exp rdy=1 rd=0 wr=0 dn=0",
                     req_ready, port_rd, port_wr, rsp_done);
        end
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog: got %0d cycles exp completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 256; i++) ec_mem[i] = 8'(i) ^ 8'hA5;
        for (int i = 0; i < 3; i++) fail_left[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        checks++;
        if (req_ready !== 1'b1 || rsp_done !== 1'b0 || port_rd !== 1'b0 || port_wr !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: got rdy=%0b dn=%0b rd=%0b wr=%0b exp rdy=1 dn=0 rd=0 wr=0",
                     req_ready, rsp_done, port_rd, port_wr);
        end
        rst_n = 1'b1;
        @(negedge clk);

        run_op(1'b0, 8'h10, 8'h5A, 0, 0, 0, 1'b0);        // R5 plain write
        run_op(1'b1, 8'h10, 8'h00, 0, 0, 0, 1'b0);        // R4 plain read, R9 data
        run_op(1'b0, 8'h22, 8'hC3, 2, 1, 3, 1'b0);        // R6 spacing
        run_op(1'b1, 8'h22, 8'h00, 1, 0, MAXP - 1, 1'b0); // R7 last allowed poll, R10 busy bit set
        run_op(1'b0, 8'h10, 8'h99, 0, NEVER, 0, 1'b0);    // R8 timeout after command
        run_op(1'b1, 8'h10, 8'h00, MAXP - 1, MAXP - 1, 0, 1'b0); // R8 value kept, R7 budget restarts
        run_op(1'b1, 8'h33, 8'h00, 0, 0, NEVER, 1'b0);    // R8 timeout on output-ready wait
        run_op(1'b0, 8'h44, 8'h11, 1, 0, 0, 1'b1);        // R2 request held and changed while busy
        run_op(1'b1, 8'h44, 8'h00, 0, 0, 0, 1'b0);        // R2 latched write value read back
        run_op(1'b0, 8'h55, 8'h77, NEVER, 0, 0, 1'b0);    // R8 timeout on first wait
        run_op(1'b1, 8'h55, 8'h00, 0, 2, 0, 1'b0);        // R8 untouched register

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule